// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter Node

Each processor on a shared external bus contains one copy of this node. Up to six peers and one host share the bus. The node drives a single request line, picked by a hardwired identifier, and watches the full set of request lines. Every copy works out the same answer from those lines, so no central arbiter is needed. Each node keeps an owner register that names the current bus holder. A node goes from requesting to mastering only after every node agrees that it owns the bus.

The owner register changes only when the owner's own request line is low. The next owner is then chosen by one of two rules, selected at run time:
- **Fixed:** the lowest-numbered requester wins.
- **Rotating:** the search starts just after the previous owner.

When nobody requests, the last owner keeps the bus parked. Three further mechanisms can take the bus away:
- **Host request:** overrides every peer. It freezes the owner register, and the owning node hands the bus to the host with a grant.
- **Core-priority line:** a slave core can raise this shared line to make a master that is doing background DMA give up the bus.
- **Suspend:** turns the bus drivers off from the next cycle and stalls any pending access.

An identifier of zero marks a single-processor system. Such a node never arbitrates.

Per-node states and transitions:
- **ST_SLAVE:** not requesting.
  - To ST_REQ when the local side wants the bus.
  - To ST_SOLO when the identifier is zero.
  - To ST_HOST when the host requests and this node owns the bus.
- **ST_REQ:** request line driven.
  - To ST_MASTER once the owner register names this node.
  - Back to ST_SLAVE if the want is withdrawn.
  - To ST_HOST on a host request while owned.
- **ST_MASTER:** drives the bus.
  - To ST_SLAVE when the want falls.
  - To ST_YIELD on a core-priority pre-emption while doing DMA.
  - To ST_HOST on a host request.
- **ST_YIELD:** request dropped.
  - To ST_SLAVE when the core-priority line clears.
  - To ST_HOST on a host request while owned.
- **ST_HOST:** grant driven.
  - To ST_SLAVE when the host request is sampled low.
  - For a solo node, to ST_SOLO instead.
- **ST_SOLO:** owns the bus without arbitration.
  - To ST_HOST on a host request.

Top module: `mpbus_node`

## Requirements
- R1: The node drives at most one bit of `req_drv`. That bit is bit `node_id-1`, where bit i stands for request line i+1. It is high exactly in ST_REQ and ST_MASTER. A node with `node_id` 0 drives no bit.
- R2: After reset, the owner register names line 1. No node drives the bus, no request line is high and no grant is driven. The node with identifier 1 reports `is_master` high, because it holds the parked bus.
- R3: With `rotate_sel` low, when the owner's request line is low and at least one line is high, the next owner is the lowest-numbered line that is high.
- R4: With `rotate_sel` high, the search for the next owner starts at the line just after the previous owner and wraps from line NODES to line 1.
- R5: While the owner's request line stays high, ownership does not change. With no request at all, the last owner stays master (parked) and does not drive the bus.
- R6: In any cycle at most one peer reports `is_master`, and at most one peer asserts `bus_drive_en`.
- R7: `bus_drive_en` is asserted only by a node that reports `is_master`. A new owner drives only after passing through ST_REQ.
- R8: When `host_req` is sampled high, the owning node stops driving and raises `host_grant_drv` from the next cycle. It holds the grant until it samples `host_req` low, and drops it the cycle after. A node that does not own the bus never drives the grant.
- R9: A node in ST_REQ with `core_urgent` and `want_bus` high raises `prio_drv` one cycle later. A master with `bg_dma` high that sees `prio_line_in` high drops its request, so the urgent requester takes the bus. Without the core-priority line, a waiting requester never pre-empts the master.
- R10: When `suspend` is sampled high, `bus_drive_en` is low from the next cycle. While `want_bus` is high and the bus is not driven, `access_stall` is high. Driving resumes one cycle after `suspend` is sampled low.
- R11: A node with `node_id` 0 drives the bus whenever `want_bus` is high and neither suspend nor host hold applies, with no arbitration delay. It yields to the host through the same grant handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | IDW | Hardwired identifier; 0 = single processor |
| rotate_sel | input | 1 | 1 = rotating priority, 0 = fixed priority |
| want_bus | input | 1 | Local core or DMA wants the external bus |
| bg_dma | input | 1 | Current local access is background DMA |
| core_urgent | input | 1 | Local core wants to pre-empt DMA on the master |
| req_lines_in | input | NODES | Observed shared request lines, bit i = line i+1 |
| req_drv | output | NODES | This node's drive onto the request lines |
| prio_line_in | input | 1 | Observed shared core-priority line |
| prio_drv | output | 1 | This node's drive onto the core-priority line |
| host_req | input | 1 | Host bus request |
| host_grant_drv | output | 1 | Host grant driven by the owning node |
| suspend | input | 1 | Forces bus drivers off from the next cycle |
| is_master | output | 1 | This node currently holds the bus |
| bus_drive_en | output | 1 | Enable for address, data, select and strobe drivers |
| access_stall | output | 1 | A wanted access is waiting |

## Verification
The bench builds six peers with the default NODES of 6 and IDW of 3, wired onto shared OR-ed request and core-priority lines, plus a separate node with identifier zero. Using all six identifiers makes several cases reachable:
- wrap-around in rotating mode, from line 6 back to line 1;
- fixed-priority choice among three simultaneous requesters;
- a host hand-off from a node that is mastering.

The solo node has its own host request, so the single-processor path can be checked without disturbing the shared bus.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;

    typedef enum logic [2:0] {
        ST_SLAVE  = 3'd0,
        ST_REQ    = 3'd1,
        ST_MASTER = 3'd2,
        ST_YIELD  = 3'd3,
        ST_HOST   = 3'd4,
        ST_SOLO   = 3'd5
    } node_st_e;

endpackage

// File: rtl/mpbus_pick.sv
// Chooses the next bus owner from the request lines.
// Fixed mode scans from line 1 upward; rotating mode starts after the last owner.
module mpbus_pick #(
    parameter int NODES = 6,
    parameter int IDW   = 3
) (
    input  logic [NODES-1:0] req_lines,
    input  logic             rotate,
    input  logic [IDW-1:0]   last_owner,
    output logic             found,
    output logic [IDW-1:0]   winner
);

    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int off = 0; off < NODES; off++) begin
            int idx;
            idx = rotate ? ((int'(last_owner) + off) % NODES) : off;
            if (!found && req_lines[idx]) begin
                found  = 1'b1;
                winner = IDW'(idx + 1);
            end
        end
    end

endmodule

// File: rtl/mpbus_owner.sv
// Replicated owner register: every node computes the same value from the shared lines.
module mpbus_owner #(
    parameter int NODES = 6,
    parameter int IDW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] req_lines,
    input  logic             rotate,
    input  logic             host_req,
    output logic [IDW-1:0]   owner
);

    logic [IDW-1:0] owner_q;
    logic           owner_line_hi;
    logic           pick_found;
    logic [IDW-1:0] pick_winner;

    mpbus_pick #(.NODES(NODES), .IDW(IDW)) u_pick (
        .req_lines  (req_lines),
        .rotate     (rotate),
        .last_owner (owner_q),
        .found      (pick_found),
        .winner     (pick_winner)
    );

    always_comb begin
        owner_line_hi = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            if (owner_q == IDW'(i + 1)) owner_line_hi = req_lines[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= IDW'(1);
        end else if (!host_req && !owner_line_hi && pick_found) begin
            owner_q <= pick_winner;
        end
    end

    assign owner = owner_q;

endmodule

// File: rtl/mpbus_node_fsm.sv
// Per-node request / master / host hand-off state machine.
module mpbus_node_fsm
    import mpbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     solo,
    input  logic     owned,
    input  logic     want_bus,
    input  logic     bg_dma,
    input  logic     core_urgent,
    input  logic     prio_line_in,
    input  logic     host_req,
    input  logic     suspend,
    output node_st_e state,
    output logic     req_on,
    output logic     drive_ok,
    output logic     grant_on,
    output logic     prio_on
);

    node_st_e state_q, state_d;
    logic     susp_q;
    logic     prio_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLAVE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLAVE: begin
                if (solo)                  state_d = ST_SOLO;
                else if (host_req && owned) state_d = ST_HOST;
                else if (want_bus)          state_d = ST_REQ;
            end
            ST_REQ: begin
                if (host_req && owned) state_d = ST_HOST;
                else if (!want_bus)    state_d = ST_SLAVE;
                else if (owned)        state_d = ST_MASTER;
            end
            ST_MASTER: begin
                if (host_req)                   state_d = ST_HOST;
                else if (bg_dma && prio_line_in) state_d = ST_YIELD;
                else if (!want_bus)             state_d = ST_SLAVE;
            end
            ST_YIELD: begin
                if (host_req && owned) state_d = ST_HOST;
                else if (!prio_line_in) state_d = ST_SLAVE;
            end
            ST_HOST: begin
                if (!host_req) state_d = solo ? ST_SOLO : ST_SLAVE;
            end
            ST_SOLO: begin
                if (host_req) state_d = ST_HOST;
            end
            default: state_d = ST_SLAVE;
        endcase
    end

    // registered side inputs: suspend takes effect next cycle, priority line drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            susp_q <= 1'b0;
            prio_q <= 1'b0;
        end else begin
            susp_q <= suspend;
            prio_q <= core_urgent && want_bus && (state_q == ST_REQ);
        end
    end

    // outputs
    always_comb begin
        req_on   = 1'b0;
        drive_ok = 1'b0;
        grant_on = 1'b0;
        unique case (state_q)
            ST_SLAVE:  ;
            ST_REQ:    req_on = 1'b1;
            ST_MASTER: begin
                req_on   = 1'b1;
                drive_ok = !susp_q;
            end
            ST_YIELD:  ;
            ST_HOST:   grant_on = 1'b1;
            ST_SOLO:   drive_ok = want_bus && !susp_q;
            default:   ;
        endcase
    end

    assign prio_on = prio_q;
    assign state   = state_q;

endmodule

// File: rtl/mpbus_node.sv
module mpbus_node
    import mpbus_pkg::*;
#(
    parameter int NODES = 6,
    parameter int IDW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDW-1:0]   node_id,
    input  logic             rotate_sel,
    input  logic             want_bus,
    input  logic             bg_dma,
    input  logic             core_urgent,
    input  logic [NODES-1:0] req_lines_in,
    output logic [NODES-1:0] req_drv,
    input  logic             prio_line_in,
    output logic             prio_drv,
    input  logic             host_req,
    output logic             host_grant_drv,
    input  logic             suspend,
    output logic             is_master,
    output logic             bus_drive_en,
    output logic             access_stall
);

    localparam int MAX_ID = NODES;

    logic           solo;
    logic           id_valid;
    logic [IDW-1:0] owner;
    logic           owned;
    node_st_e       state;
    logic           req_on;
    logic           drive_ok;
    logic           grant_on;
    logic           prio_on;

    assign solo     = (node_id == '0);
    assign id_valid = !solo && (int'(node_id) <= MAX_ID);

    mpbus_owner #(.NODES(NODES), .IDW(IDW)) u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_lines (req_lines_in),
        .rotate    (rotate_sel),
        .host_req  (host_req),
        .owner     (owner)
    );

    assign owned = id_valid && (owner == node_id);

    mpbus_node_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .solo         (solo),
        .owned        (owned),
        .want_bus     (want_bus),
        .bg_dma       (bg_dma),
        .core_urgent  (core_urgent),
        .prio_line_in (prio_line_in),
        .host_req     (host_req),
        .suspend      (suspend),
        .state        (state),
        .req_on       (req_on),
        .drive_ok     (drive_ok),
        .grant_on     (grant_on),
        .prio_on      (prio_on)
    );

    for (genvar g = 0; g < NODES; g++) begin : g_line
        assign req_drv[g] = req_on && (node_id == IDW'(g + 1));
    end

    assign prio_drv       = prio_on;
    assign host_grant_drv = grant_on;
    assign bus_drive_en   = drive_ok;
    assign is_master      = (state != ST_HOST) && (solo || owned);
    assign access_stall   = want_bus && !drive_ok;

endmodule

// File: rtl/mpbus_node_chk.sv
module mpbus_node_chk #(
    parameter int NODES = 6,
    parameter int IDW   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDW-1:0]   node_id,
    input logic             host_req,
    input logic             suspend,
    input logic [NODES-1:0] req_drv,
    input logic             host_grant_drv,
    input logic             bus_drive_en,
    input logic             is_master
);

    // R1: only the node's own line is ever driven
    a_r1_own_line: assert property (@(posedge clk) disable iff (!rst_n)
        (node_id != '0 && req_drv != '0) |-> (req_drv == (NODES'(1) << (node_id - IDW'(1)))));

    // R11: a solo node never drives a request line
    a_r11_solo_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (node_id == '0) |-> (req_drv == '0));

    // R7: only the master drives the bus
    a_r7_drive_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_en |-> is_master);

    // R8: grant appears only after a sampled host request
    a_r8_grant_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_grant_drv) |-> $past(host_req));

    // R8: grant dropped the cycle after the request is seen low
    a_r8_grant_release: assert property (@(posedge clk) disable iff (!rst_n)
        (host_grant_drv && !host_req) |=> !host_grant_drv);

    // R8: no bus drive while the host holds the bus
    a_r8_no_drive_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant_drv |-> !bus_drive_en);

    // R10: drivers off the cycle after suspend
    a_r10_suspend_off: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> !bus_drive_en);

endmodule

bind mpbus_node mpbus_node_chk #(.NODES(NODES), .IDW(IDW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .node_id        (node_id),
    .host_req       (host_req),
    .suspend        (suspend),
    .req_drv        (req_drv),
    .host_grant_drv (host_grant_drv),
    .bus_drive_en   (bus_drive_en),
    .is_master      (is_master)
);

// File: tb/sim_mpbus_node.sv
module sim_mpbus_node;

    localparam int PERIOD = 10;
    localparam int NODES  = 6;
    localparam int IDW    = 3;
    localparam int SETTLE = 8;
    localparam int NVEC   = 14;

    // {rotate, host, want[6], exp_driver[3], exp_master[3], exp_grant}
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 6'b000000, 3'd0, 3'd1, 1'b0},
        {1'b0, 1'b0, 6'b010100, 3'd3, 3'd3, 1'b0},
        {1'b0, 1'b0, 6'b010000, 3'd5, 3'd5, 1'b0},
        {1'b0, 1'b0, 6'b101010, 3'd2, 3'd2, 1'b0},
        {1'b0, 1'b0, 6'b101000, 3'd4, 3'd4, 1'b0},
        {1'b1, 1'b0, 6'b100011, 3'd6, 3'd6, 1'b0},
        {1'b1, 1'b0, 6'b000011, 3'd1, 3'd1, 1'b0},
        {1'b1, 1'b0, 6'b010110, 3'd2, 3'd2, 1'b0},
        {1'b1, 1'b0, 6'b010101, 3'd3, 3'd3, 1'b0},
        {1'b1, 1'b0, 6'b010001, 3'd5, 3'd5, 1'b0},
        {1'b0, 1'b0, 6'b100001, 3'd1, 3'd1, 1'b0},
        {1'b0, 1'b1, 6'b100001, 3'd0, 3'd0, 1'b1},
        {1'b0, 1'b0, 6'b100000, 3'd6, 3'd6, 1'b0},
        {1'b0, 1'b0, 6'b000000, 3'd0, 3'd6, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(PERIOD / 2) clk = ~clk;

    logic             rot = 1'b0;
    logic             host = 1'b0;
    logic [NODES-1:0] want_v = '0;
    logic [NODES-1:0] dma_v = '0;
    logic [NODES-1:0] urg_v = '0;
    logic [NODES-1:0] susp_v = '0;
    logic [NODES-1:0] req_lines;
    logic [NODES-1:0] req_m [NODES];
    logic [NODES-1:0] prio_v, grant_v, master_v, drive_v, stall_v;
    logic             prio_line;

    for (genvar k = 0; k < NODES; k++) begin : g_peer
        mpbus_node #(.NODES(NODES), .IDW(IDW)) u0 (
            .clk            (clk),
            .rst_n          (rst_n),
            .node_id        (IDW'(k + 1)),
            .rotate_sel     (rot),
            .want_bus       (want_v[k]),
            .bg_dma         (dma_v[k]),
            .core_urgent    (urg_v[k]),
            .req_lines_in   (req_lines),
            .req_drv        (req_m[k]),
            .prio_line_in   (prio_line),
            .prio_drv       (prio_v[k]),
            .host_req       (host),
            .host_grant_drv (grant_v[k]),
            .suspend        (susp_v[k]),
            .is_master      (master_v[k]),
            .bus_drive_en   (drive_v[k]),
            .access_stall   (stall_v[k])
        );
    end

    always_comb begin
        req_lines = '0;
        for (int k = 0; k < NODES; k++) req_lines = req_lines | req_m[k];
    end
    assign prio_line = |prio_v;

    // separate single-processor node
    logic             s_want = 1'b0, s_host = 1'b0;
    logic [NODES-1:0] s_req;
    logic             s_prio, s_grant, s_master, s_drive, s_stall;

    mpbus_node #(.NODES(NODES), .IDW(IDW)) u_solo (
        .clk            (clk),
        .rst_n          (rst_n),
        .node_id        ('0),
        .rotate_sel     (1'b0),
        .want_bus       (s_want),
        .bg_dma         (1'b0),
        .core_urgent    (1'b0),
        .req_lines_in   ('0),
        .req_drv        (s_req),
        .prio_line_in   (1'b0),
        .prio_drv       (s_prio),
        .host_req       (s_host),
        .host_grant_drv (s_grant),
        .suspend        (1'b0),
        .is_master      (s_master),
        .bus_drive_en   (s_drive),
        .access_stall   (s_stall)
    );

    int nchecks = 0;
    int nerr = 0;
    int viol = 0;
    bit done = 1'b0;

    function automatic int which(logic [NODES-1:0] v);
        if ($countones(v) > 1) return 7;
        for (int k = 0; k < NODES; k++) if (v[k]) return k + 1;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // R6: continuous single-master monitor
    always @(negedge clk) begin
        if (rst_n && ($countones(master_v) > 1 || $countones(drive_v) > 1)) viol++;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // R2: reset state
        check("R2 master after reset", which(master_v), 1);
        check("R2 no drive after reset", which(drive_v), 0);
        check("R2 no request after reset", int'(req_lines), 0);
        check("R2 no grant after reset", int'(|grant_v), 0);

        // table walk: R1, R3, R4, R5, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] v;
            string       mtag;
            v      = VEC[i];
            rot    = v[14];
            host   = v[13];
            want_v = v[12:7];
            cycles(SETTLE);
            if (v[13])      mtag = "R8 master during host";
            else if (i == NVEC - 1) mtag = "R5 parked master";
            else if (v[14]) mtag = "R4 rotating master";
            else            mtag = "R3 fixed master";
            check("R7 driving node", which(drive_v), int'(v[6:4]));
            check(mtag, which(master_v), int'(v[3:1]));
            check("R8 host grant", int'(|grant_v), int'(v[0]));
            if (!v[13]) check("R1 request lines", int'(req_lines), int'(v[12:7]));
        end
        host = 1'b0;

        // R10: suspend on node 3
        want_v = 6'b000100;
        cycles(SETTLE);
        check("R10 driving before suspend", int'(drive_v[2]), 1);
        susp_v[2] = 1'b1;
        cycles(1);
        check("R10 drive off after suspend", int'(drive_v[2]), 0);
        check("R10 stall during suspend", int'(stall_v[2]), 1);
        cycles(2);
        check("R10 still off", int'(drive_v[2]), 0);
        susp_v[2] = 1'b0;
        cycles(1);
        check("R10 drive resumes", int'(drive_v[2]), 1);
        check("R10 stall cleared", int'(stall_v[2]), 0);
        want_v = '0;
        cycles(4);

        // R9: core-priority pre-emption of background DMA
        dma_v[1] = 1'b1;
        want_v   = 6'b000010;
        cycles(SETTLE);
        check("R9 DMA master", which(drive_v), 2);
        want_v = 6'b010010;
        cycles(SETTLE);
        check("R9 no pre-emption without line", which(drive_v), 2);
        urg_v[4] = 1'b1;
        cycles(1);
        check("R9 priority line raised", int'(prio_v[4]), 1);
        cycles(SETTLE);
        check("R9 urgent core wins", which(drive_v), 5);
        check("R9 priority line released", int'(prio_line), 0);
        want_v = '0;
        urg_v  = '0;
        dma_v  = '0;
        cycles(4);

        // R8: grant timing from a parked owner (node 5)
        host = 1'b1;
        cycles(1);
        check("R8 grant next cycle", int'(|grant_v), 1);
        check("R8 grant from owner", which(grant_v), 5);
        cycles(3);
        check("R8 grant held", int'(|grant_v), 1);
        host = 1'b0;
        cycles(1);
        check("R8 grant released", int'(|grant_v), 0);

        // R11: single-processor node
        check("R11 solo master idle", int'(s_master), 1);
        s_want = 1'b1;
        cycles(1);
        check("R11 solo drives", int'(s_drive), 1);
        check("R11 solo no request", int'(s_req), 0);
        s_host = 1'b1;
        cycles(1);
        check("R11 solo yields to host", int'(s_drive), 0);
        check("R11 solo grant", int'(s_grant), 1);
        s_host = 1'b0;
        cycles(2);
        check("R11 solo drives again", int'(s_drive), 1);

        check("R6 single master monitor", viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule